// File: doc/BRIEF.md
# CMI Line Codec

This block converts between NRZ data and a Code Mark Inversion (CMI) line signal for a unipolar optical-style link. Every data bit takes two line half-symbols. A one is a flat level held for the whole bit, and successive ones alternate between high and low. A zero is a low half followed by a high half. The single clock `clk` runs at twice the bit rate, so each clock cycle carries one half-symbol in each direction.

The transmit side asks for a data bit every other cycle and drives the two half-symbols on `tx_line`. The receive side samples `rx_line` once per cycle and groups the samples into pairs. It uses the illegal pair "10" to find the correct half-bit phase. It decodes each pair and flags code violations. One enable, `cmi_en`, switches both directions together. When the enable is clear, both directions pass plain NRZ data through with the same timing. The enable is meant to change only while reset is asserted.

Top module: `cmi_codec`

## Requirements
- R1: In CMI mode, a one bit drives `tx_line` to the same level in both halves. Successive ones alternate in level, and the first one after reset is high.
- R2: In CMI mode, a zero bit drives `tx_line` low in the first half and high in the second half.
- R3: `tx_bit_req` is high in the first cycle after reset and then on every other cycle. The bit on `tx_nrz` is taken at a rising edge where `tx_bit_req` is high. Its first half appears on `tx_line` after that edge and its second half after the next edge.
- R4: With `cmi_en` low, `tx_line` carries the taken bit in both halves. `rx_data` is the second-half sample of each pair, and `rx_viol` stays low.
- R5: With reset released, number the rising edges from 1. The receiver pairs the samples taken at edges 2k and 2k+1 for k ≥ 1, until a phase slip occurs. Pairs "11" and "00" decode to 1 and "01" decodes to 0. Each decoded bit gives a one-cycle `rx_valid` pulse.
- R6: `rx_valid` rises four rising edges (two bit periods) after the edge that samples the second half of its pair. In loopback, this is six edges after the transmit side takes the bit.
- R7: In CMI mode, the pair "10" decodes with `rx_data` = 0 and `rx_viol` = 1 in the same cycle as its `rx_valid`.
- R8: In CMI mode, a one whose level equals the level of the previous decoded one has `rx_viol` = 1.
- R9: The receiver counts "10" pairs over windows of 16 decoded bits. If a window holds more than 4 of them, the pairing shifts by one half-symbol. Exactly 4 cause no shift.
- R10: While reset is held, `tx_line`, `rx_valid` and `rx_viol` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| cmi_en | input | 1 | 1 = CMI coding in both directions, 0 = plain pass-through |
| tx_nrz | input | 1 | Transmit data bit |
| tx_bit_req | output | 1 | Transmit bit is taken at the next rising edge |
| tx_line | output | 1 | Line half-symbol out |
| rx_line | input | 1 | Line half-symbol in, sampled every cycle |
| rx_data | output | 1 | Decoded bit, valid with rx_valid |
| rx_valid | output | 1 | One-cycle strobe per decoded bit |
| rx_viol | output | 1 | Code violation on the bit under rx_valid |

## Verification
The bench builds the block with its defaults: a 16-bit window, a threshold of 4 and a two-bit-period receive latency. With these values both sides of the slip boundary take under twenty bits to reach. A window holding exactly 4 illegal pairs must leave the alignment alone, while a stream that starts half a symbol late produces 8 and must be realigned. A loopback path lets the transmit shapes, the level alternation of ones and the fixed latency be checked against one sent bit sequence. Direct drive of the receive line supplies illegal pairs and same-level ones that the transmitter never sends.

// File: rtl/cmi_codec_pkg.sv
package cmi_codec_pkg;

   typedef struct packed {
      logic early;
      logic late;
   } half_pair_t;

   typedef enum logic [1:0] {
      SYM_ZERO = 2'd0,
      SYM_HIGH = 2'd1,
      SYM_LOW  = 2'd2,
      SYM_BAD  = 2'd3
   } line_sym_e;

   function automatic line_sym_e classify_pair(input half_pair_t p);
      case ({p.early, p.late})
         2'b01:   return SYM_ZERO;
         2'b11:   return SYM_HIGH;
         2'b00:   return SYM_LOW;
         default: return SYM_BAD;
      endcase
   endfunction

endpackage

// File: rtl/cmi_enc.sv
module cmi_enc (
   input  logic clk,
   input  logic rst_n,
   input  logic cmi_en,
   input  logic tx_nrz,
   output logic tx_bit_req,
   output logic tx_line
);
   logic half_q;
   logic mark_lvl_q;
   logic late_q;
   logic line_q;

   assign tx_bit_req = ~half_q;
   assign tx_line    = line_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         half_q     <= 1'b0;
         mark_lvl_q <= 1'b1;
         late_q     <= 1'b0;
         line_q     <= 1'b0;
      end else begin
         half_q <= ~half_q;
         if (!half_q) begin
            if (!cmi_en) begin
               line_q <= tx_nrz;
               late_q <= tx_nrz;
            end else if (!tx_nrz) begin
               line_q <= 1'b0;
               late_q <= 1'b1;
            end else begin
               line_q     <= mark_lvl_q;
               late_q     <= mark_lvl_q;
               mark_lvl_q <= ~mark_lvl_q;
            end
         end else begin
            line_q <= late_q;
         end
      end
   end
endmodule

// File: rtl/cmi_align.sv
module cmi_align #(
   parameter int WIN_BITS    = 16,
   parameter int SLIP_THRESH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmi_en,
   input  logic pair_bad,
   output logic dec_stb
);
   localparam int BW = (WIN_BITS > 2) ? $clog2(WIN_BITS) : 1;
   localparam int CW = $clog2(WIN_BITS + 1);

   logic          ph_q;
   logic          primed_q;
   logic [BW-1:0] bit_cnt_q;
   logic [CW-1:0] bad_cnt_q;
   logic [CW-1:0] bad_next;
   logic          win_end;
   logic          slip;

   assign dec_stb  = ph_q & primed_q;
   assign bad_next = bad_cnt_q + CW'(pair_bad & cmi_en);
   assign win_end  = (bit_cnt_q == BW'(WIN_BITS - 1));
   assign slip     = dec_stb & cmi_en & win_end & (bad_next > CW'(SLIP_THRESH));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q      <= 1'b0;
         primed_q  <= 1'b0;
         bit_cnt_q <= '0;
         bad_cnt_q <= '0;
      end else begin
         primed_q <= primed_q | ph_q;
         ph_q     <= slip ? ph_q : ~ph_q;
         if (dec_stb) begin
            if (win_end) begin
               bit_cnt_q <= '0;
               bad_cnt_q <= '0;
            end else begin
               bit_cnt_q <= bit_cnt_q + BW'(1);
               bad_cnt_q <= bad_next;
            end
         end
      end
   end
endmodule

// File: rtl/cmi_dec.sv
module cmi_dec
   import cmi_codec_pkg::*;
#(
   parameter int LAT_CLK = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmi_en,
   input  logic rx_line,
   input  logic dec_stb,
   output logic pair_bad,
   output logic rx_data,
   output logic rx_valid,
   output logic rx_viol
);
   logic       s_now_q;
   logic       s_prev_q;
   logic       last_lvl_q;
   logic       have_one_q;
   half_pair_t pair;
   line_sym_e  sym;
   logic       is_one;
   logic [2:0] stage_in;

   assign pair     = '{early: s_prev_q, late: s_now_q};
   assign sym      = classify_pair(pair);
   assign pair_bad = (sym == SYM_BAD);
   assign is_one   = (sym == SYM_HIGH) || (sym == SYM_LOW);

   always_comb begin
      if (cmi_en) begin
         stage_in = {dec_stb, is_one,
                     pair_bad | (is_one & have_one_q & (s_now_q == last_lvl_q))};
      end else begin
         stage_in = {dec_stb, s_now_q, 1'b0};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_now_q    <= 1'b0;
         s_prev_q   <= 1'b0;
         last_lvl_q <= 1'b0;
         have_one_q <= 1'b0;
      end else begin
         s_prev_q <= s_now_q;
         s_now_q  <= rx_line;
         if (dec_stb && cmi_en && is_one) begin
            last_lvl_q <= s_now_q;
            have_one_q <= 1'b1;
         end
      end
   end

   for (genvar i = 0; i < LAT_CLK; i++) begin : g_stage
      logic [2:0] q;
      if (i == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= stage_in;
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= g_stage[i-1].q;
         end
      end
   end

   assign rx_valid = g_stage[LAT_CLK-1].q[2];
   assign rx_data  = g_stage[LAT_CLK-1].q[1] & g_stage[LAT_CLK-1].q[2];
   assign rx_viol  = g_stage[LAT_CLK-1].q[0] & g_stage[LAT_CLK-1].q[2];
endmodule

// File: rtl/cmi_codec.sv
module cmi_codec #(
   parameter int WIN_BITS    = 16,
   parameter int SLIP_THRESH = 4,
   parameter int RX_LAT_BITS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmi_en,
   input  logic tx_nrz,
   output logic tx_bit_req,
   output logic tx_line,
   input  logic rx_line,
   output logic rx_data,
   output logic rx_valid,
   output logic rx_viol
);
   localparam int LAT_CLK = 2 * RX_LAT_BITS;

   if (WIN_BITS < 2) begin : g_bad_win
      $error("cmi_codec: WIN_BITS must be at least 2");
   end
   if (SLIP_THRESH < 0 || SLIP_THRESH >= WIN_BITS) begin : g_bad_thr
      $error("cmi_codec: SLIP_THRESH must lie in 0..WIN_BITS-1");
   end
   if (RX_LAT_BITS < 1) begin : g_bad_lat
      $error("cmi_codec: RX_LAT_BITS must be at least 1");
   end

   logic dec_stb;
   logic pair_bad;

   cmi_enc u_enc (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmi_en     (cmi_en),
      .tx_nrz     (tx_nrz),
      .tx_bit_req (tx_bit_req),
      .tx_line    (tx_line)
   );

   cmi_align #(
      .WIN_BITS    (WIN_BITS),
      .SLIP_THRESH (SLIP_THRESH)
   ) u_align (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmi_en   (cmi_en),
      .pair_bad (pair_bad),
      .dec_stb  (dec_stb)
   );

   cmi_dec #(
      .LAT_CLK (LAT_CLK)
   ) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmi_en   (cmi_en),
      .rx_line  (rx_line),
      .dec_stb  (dec_stb),
      .pair_bad (pair_bad),
      .rx_data  (rx_data),
      .rx_valid (rx_valid),
      .rx_viol  (rx_viol)
   );
endmodule

// File: rtl/cmi_codec_chk.sv
module cmi_codec_chk (
   input logic clk,
   input logic rst_n,
   input logic cmi_en,
   input logic tx_nrz,
   input logic tx_bit_req,
   input logic tx_line,
   input logic rx_line,
   input logic rx_data,
   input logic rx_valid,
   input logic rx_viol
);
   assert_one_flat_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmi_en && tx_bit_req && tx_nrz) |=> ##1 $stable(tx_line));

   assert_zero_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmi_en && tx_bit_req && !tx_nrz) |=> (!tx_line) ##1 tx_line);

   assert_req_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_bit_req |=> !tx_bit_req);

   assert_req_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_bit_req |=> tx_bit_req);

   assert_plain_tx_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmi_en && tx_bit_req) |=> (tx_line == $past(tx_nrz)));

   assert_plain_rx_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cmi_en |-> !rx_viol);

   assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !cmi_en) |=> !rx_valid);

   assert_viol_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_viol |-> rx_valid);
endmodule

bind cmi_codec cmi_codec_chk u_chk (.*);

// File: tb/cmi_codec_bench.sv
module cmi_codec_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmi_en = 1'b1;
   logic tx_nrz = 1'b0;
   logic tx_bit_req, tx_line, rx_data, rx_valid, rx_viol;
   logic loop_sel = 1'b1;
   logic drv_line = 1'b0;
   logic rx_line;

   assign rx_line = loop_sel ? tx_line : drv_line;

   always #2 clk = ~clk;

   cmi_codec u_cmi_codec (
      .clk(clk), .rst_n(rst_n), .cmi_en(cmi_en), .tx_nrz(tx_nrz),
      .tx_bit_req(tx_bit_req), .tx_line(tx_line), .rx_line(rx_line),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_viol(rx_viol)
   );

   int nvec = 0;
   int nbad = 0;
   int cyc = 0;
   int mon_mode = 0;
   int nsent = 0;
   int rx_idx = 0;
   int log_n = 0;
   int rel0 = 0;
   bit done = 0;
   logic sent [64];
   int   sent_cyc [64];
   logic log_d [64];
   logic log_v [64];
   int   log_c [64];

   // {bit, first half, second half}
   localparam logic [2:0] VEC [12] = '{
      3'b111, 3'b001, 3'b100, 3'b111, 3'b001, 3'b001,
      3'b100, 3'b001, 3'b111, 3'b100, 3'b111, 3'b001 };

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nvec++; nbad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   always @(negedge clk) begin
      if (rst_n && rx_valid && mon_mode == 1) begin
         if (rx_idx < nsent) begin
            chk(rx_data == sent[rx_idx], "R5 loopback data", int'(rx_data), int'(sent[rx_idx]));
            chk(cyc - sent_cyc[rx_idx] == 6, "R6 loopback latency", cyc - sent_cyc[rx_idx], 6);
            chk(!rx_viol, "R7 R8 no violation on legal stream", int'(rx_viol), 0);
         end
         rx_idx++;
      end else if (rst_n && rx_valid && mon_mode == 2 && log_n < 64) begin
         log_d[log_n] = rx_data;
         log_v[log_n] = rx_viol;
         log_c[log_n] = cyc;
         log_n++;
      end
   end

   task automatic do_reset(input logic en, input logic loop);
      rst_n = 1'b0;
      mon_mode = 0;
      cmi_en = en;
      loop_sel = loop;
      repeat (3) @(negedge clk);
      nsent = 0; rx_idx = 0; log_n = 0;
      rst_n = 1'b1;
      rel0 = cyc;
   endtask

   task automatic send_bit(input logic b, input logic h1, input logic h2, input string tag);
      tx_nrz = b;
      chk(tx_bit_req == 1'b1, "R3 bit request", int'(tx_bit_req), 1);
      sent[nsent] = b;
      @(negedge clk);
      sent_cyc[nsent] = cyc;
      nsent++;
      chk(tx_line == h1, {tag, " first half"}, int'(tx_line), int'(h1));
      chk(tx_bit_req == 1'b0, "R3 request low in second half", int'(tx_bit_req), 0);
      @(negedge clk);
      chk(tx_line == h2, {tag, " second half"}, int'(tx_line), int'(h2));
   endtask

   task automatic drive_half(input logic v);
      drv_line = v;
      @(negedge clk);
   endtask

   task automatic drive_pair(input logic a, input logic b);
      drive_half(a);
      drive_half(b);
   endtask

   initial begin
      // R10: reset state
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(tx_line == 1'b0, "R10 tx_line in reset", int'(tx_line), 0);
      chk(rx_valid == 1'b0, "R10 rx_valid in reset", int'(rx_valid), 0);
      chk(rx_viol == 1'b0, "R10 rx_viol in reset", int'(rx_viol), 0);

      // R1 R2 R3 R5 R6: table walk in CMI loopback
      do_reset(1'b1, 1'b1);
      mon_mode = 1;
      for (int i = 0; i < 12; i++)
         send_bit(VEC[i][2], VEC[i][1], VEC[i][0], VEC[i][2] ? "R1 one" : "R2 zero");
      repeat (10) @(negedge clk);
      chk(rx_idx >= nsent, "R5 all bits decoded", rx_idx, nsent);

      // R4: pass-through in both directions
      do_reset(1'b0, 1'b1);
      mon_mode = 1;
      send_bit(1'b1, 1'b1, 1'b1, "R4 plain one");
      send_bit(1'b1, 1'b1, 1'b1, "R4 plain one");
      send_bit(1'b0, 1'b0, 1'b0, "R4 plain zero");
      send_bit(1'b1, 1'b1, 1'b1, "R4 plain one");
      send_bit(1'b0, 1'b0, 1'b0, "R4 plain zero");
      tx_nrz = 1'b0;
      repeat (10) @(negedge clk);
      chk(rx_idx >= nsent, "R4 plain bits decoded", rx_idx, nsent);

      // R7 R8 R6: direct drive with illegal pair and same-level ones
      do_reset(1'b1, 1'b0);
      mon_mode = 2;
      drive_half(1'b0);
      drive_pair(1'b1, 1'b1);
      drive_pair(1'b0, 1'b1);
      drive_pair(1'b1, 1'b0);
      drive_pair(1'b0, 1'b0);
      drive_pair(1'b0, 1'b0);
      drive_pair(1'b0, 1'b1);
      for (int i = 0; i < 4; i++) drive_pair(1'b0, 1'b1);
      chk(log_n >= 6, "R5 decode count", log_n, 6);
      chk(log_c[0] - rel0 == 7, "R6 first strobe edge", log_c[0] - rel0, 7);
      chk(log_d[0] == 1'b1 && !log_v[0], "R5 high one", int'(log_d[0]), 1);
      chk(log_d[1] == 1'b0 && !log_v[1], "R5 zero", int'(log_d[1]), 0);
      chk(log_d[2] == 1'b0 && log_v[2], "R7 illegal pair flagged", int'(log_v[2]), 1);
      chk(log_d[3] == 1'b1 && !log_v[3], "R8 low one after high", int'(log_v[3]), 0);
      chk(log_d[4] == 1'b1 && log_v[4], "R8 repeated low one", int'(log_v[4]), 1);
      chk(log_d[5] == 1'b0 && !log_v[5], "R5 zero after violation", int'(log_v[5]), 0);

      // R9: exactly four illegal pairs in a window, no slip
      do_reset(1'b1, 1'b0);
      mon_mode = 2;
      drive_half(1'b0);
      for (int i = 0; i < 16; i++) begin
         if (i % 4 == 1) drive_pair(1'b1, 1'b0);
         else            drive_pair(1'b0, 1'b1);
      end
      for (int i = 0; i < 6; i++) begin
         if (i % 2 == 0) drive_pair(1'b1, 1'b1);
         else            drive_pair(1'b0, 1'b0);
      end
      for (int i = 0; i < 4; i++) drive_pair(1'b0, 1'b1);
      chk(log_n >= 22, "R9 decode count at threshold", log_n, 22);
      for (int i = 16; i < 22; i++)
         chk(log_d[i] == 1'b1 && !log_v[i], "R9 no slip at four", int'(log_d[i]) * 2 + int'(log_v[i]), 2);

      // R9: half-symbol late stream forces a slip
      do_reset(1'b1, 1'b0);
      mon_mode = 2;
      drive_half(1'b0);
      drive_half(1'b0);
      for (int i = 0; i < 40; i++) begin
         if (i % 2 == 0) drive_pair(1'b1, 1'b1);
         else            drive_pair(1'b0, 1'b0);
      end
      for (int i = 0; i < 4; i++) drive_pair(1'b0, 1'b1);
      chk(log_n >= 40, "R9 decode count after slip", log_n, 40);
      begin
         int early_bad = 0;
         for (int i = 0; i < 16; i++) early_bad += int'(log_v[i]);
         chk(early_bad > 4, "R9 misaligned stream flagged", early_bad, 8);
      end
      for (int i = 28; i < 38; i++)
         chk(log_d[i] == 1'b1 && !log_v[i], "R9 realigned ones", int'(log_d[i]) * 2 + int'(log_v[i]), 2);

      finish_run();
   end
endmodule